// File: doc/BRIEF.md
# Real-Time-Clock Hour Register with 12/24-Hour and BCD/Binary Encoding

This block holds the hour of day for a real-time clock. Each pulse on the hour-tick input moves it forward by one hour. The hour is kept as one byte in the encoding that the present mode and format inputs select. The mode is either a 24-hour count or a 12-hour count with an afternoon flag in the top bit. The format is either packed BCD or plain binary. When the time passes from the last hour of the day to midnight, the block raises a one-cycle day-carry pulse that advances the date logic next to it.

A host writes an hour byte through a valid/ready write channel. `wr_ready` is tied high, so the channel never applies back-pressure. A write is accepted on every rising clock edge where `wr_valid` is high. The written byte is taken to be in the encoding selected by the mode and format inputs in that same cycle. The read port always shows the stored byte.

When either the mode or the format input changes, the block re-encodes the stored hour into the new encoding. The time of day stays the same. The re-encoding takes one cycle.

Top module: `hour_counter_rtc`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_hour` reads 0x00 and `day_carry` is low. The reset state is midnight in 24-hour BCD.
- R2: With `mode_12h` low, hour h (0..23) is stored as the value h, and bit 7 is always clear. Midnight reads 0 and 13:00 reads 13.
- R3: With `mode_12h` high, bit 7 is the afternoon flag and bit 6 is zero. Bits 5:0 hold 12 for the first hour after midnight and after noon, and 1..11 for the others. Midnight reads 0x12 (BCD), noon 0x92 (BCD), and 11 PM 0x91 (BCD).
- R4: With `fmt_bin` low, the hour value is packed BCD, with tens in the upper nibble of its field (0x23 means 23). With `fmt_bin` high, it is plain binary (0x17 means 23).
- R5: A `tick` with no write advances the hour by one, visible on `rd_hour` after that edge. The count wraps from 23 to 0. In 12-hour mode, 11 AM goes to 12 PM and 11 PM goes to 12 AM.
- R6: `day_carry` is high for exactly the one cycle after the tick edge that moves the last hour of the day to midnight. At all other times it is low.
- R7: A change of `mode_12h` or `fmt_bin` re-encodes the stored hour into the new encoding one edge later, keeping the same time of day.
- R8: A write stores `wr_data` unchanged, visible on `rd_hour` after the accepting edge. A write in the same cycle as a tick wins, and no carry is produced. `wr_ready` is always high.
- R9: A stored byte that is not a legal hour in the current encoding is left unchanged by ticks and by mode or format changes, and it never produces a carry. Examples: 0x25 in 24-hour BCD, or 0x00 in 12-hour mode.
- R10: With no tick, no write and unchanged mode and format, `rd_hour` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that advances the hour |
| mode_12h | input | 1 | 1 = 12-hour encoding with afternoon flag, 0 = 24-hour |
| fmt_bin | input | 1 | 1 = binary value, 0 = packed BCD |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accept, tied high |
| wr_data | input | 8 | Hour byte to store, in the current encoding |
| rd_hour | output | 8 | Stored hour byte |
| day_carry | output | 1 | One-cycle pulse at midnight rollover |

## Verification
The stored byte is the only state that carries time. A wrong decode, step or encode therefore shows on `rd_hour` at the first edge after the offending tick or mode change, and it stays wrong from then on. The bench sweeps every hour through ticks and through every ordered pair of encodings, so an off-by-one or a misplaced flag appears within one cycle of the hour where it occurs. A misplaced carry shows on `day_carry` in the same cycle as the hour wrap.

// File: rtl/hour_pkg.sv
`timescale 1ns/1ps
package hour_pkg;
  localparam int HBYTE_W   = 8;
  localparam int HOURS_DAY = 24;
  localparam int HOUR_W    = $clog2(HOURS_DAY);
  localparam int PM_POS    = HBYTE_W - 1;

  // Encode a value 0..23 as binary or packed BCD in one byte.
  function automatic logic [HBYTE_W-1:0] pack_val(input logic [HOUR_W-1:0] v,
                                                  input logic bin);
    logic [HBYTE_W-1:0] w;
    w = {{(HBYTE_W-HOUR_W){1'b0}}, v};
    if (bin) return w;
    return HBYTE_W'((w / 8'd10) * 8'd16 + (w % 8'd10));
  endfunction
endpackage

// File: rtl/hour_decode.sv
`timescale 1ns/1ps
module hour_decode
  import hour_pkg::*;
(
  input  logic [HBYTE_W-1:0] hbyte,
  input  logic               mode12,
  input  logic               bin,
  output logic [HOUR_W-1:0]  h24,
  output logic               ok
);
  logic [HBYTE_W-1:0] field;
  logic [HBYTE_W-1:0] val;
  logic               digits_ok;
  logic               range_ok;
  logic [HOUR_W-1:0]  base;
  logic [HOUR_W-1:0]  h;

  always_comb begin
    // In 12-hour mode the value lives in bits 5:0; bits 7:6 are flag and zero.
    field = mode12 ? {2'b00, hbyte[5:0]} : hbyte;
    if (bin) begin
      val       = field;
      digits_ok = 1'b1;
    end else begin
      digits_ok = (field[7:4] < 4'd10) && (field[3:0] < 4'd10);
      val       = HBYTE_W'({4'h0, field[7:4]} * 8'd10) + {4'h0, field[3:0]};
    end
    base = '0;
    h    = '0;
    if (mode12) begin
      range_ok = !hbyte[6] && (val >= 8'd1) && (val <= 8'd12);
      base     = (val[HOUR_W-1:0] == HOUR_W'(12)) ? '0 : val[HOUR_W-1:0];
      h        = hbyte[PM_POS] ? base + HOUR_W'(12) : base;
    end else begin
      range_ok = val <= 8'(HOURS_DAY - 1);
      h        = val[HOUR_W-1:0];
    end
    ok  = digits_ok && range_ok;
    h24 = ok ? h : '0;
  end
endmodule

// File: rtl/hour_encode.sv
`timescale 1ns/1ps
module hour_encode
  import hour_pkg::*;
(
  input  logic [HOUR_W-1:0]  h24,
  input  logic               mode12,
  input  logic               bin,
  output logic [HBYTE_W-1:0] hbyte
);
  logic              pm;
  logic [HOUR_W-1:0] v12;
  logic [HBYTE_W-1:0] p;

  always_comb begin
    pm  = h24 >= HOUR_W'(12);
    v12 = pm ? h24 - HOUR_W'(12) : h24;
    if (v12 == '0) v12 = HOUR_W'(12);
    p = pack_val(mode12 ? v12 : h24, bin);
    if (mode12) hbyte = {pm, 1'b0, 6'b0} | (p & 8'h3F);
    else        hbyte = p;
  end
endmodule

// File: rtl/hour_step.sv
`timescale 1ns/1ps
module hour_step
  import hour_pkg::*;
#(
  parameter int HOURS = HOURS_DAY
) (
  input  logic [HOUR_W-1:0] h_in,
  input  logic              ok,
  input  logic              adv,
  output logic [HOUR_W-1:0] h_out,
  output logic              wrap
);
  localparam logic [HOUR_W-1:0] LAST = HOUR_W'(HOURS - 1);

  always_comb begin
    wrap  = adv && ok && (h_in == LAST);
    h_out = h_in;
    if (adv && ok) h_out = wrap ? '0 : h_in + 1'b1;
  end
endmodule

// File: rtl/hour_counter_rtc.sv
`timescale 1ns/1ps
module hour_counter_rtc
  import hour_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               mode_12h,
  input  logic               fmt_bin,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [HBYTE_W-1:0] wr_data,
  output logic [HBYTE_W-1:0] rd_hour,
  output logic               day_carry
);
  logic [HBYTE_W-1:0] raw_q;
  logic               mode_q, fmt_q, carry_q;
  logic [HOUR_W-1:0]  h_cur, h_nxt;
  logic               cur_ok, wrap;
  logic [HBYTE_W-1:0] enc_byte;

  // The stored byte is in the encoding of the previous cycle's mode and format.
  hour_decode u_dec (.hbyte(raw_q), .mode12(mode_q), .bin(fmt_q),
                     .h24(h_cur), .ok(cur_ok));
  hour_step #(.HOURS(HOURS_DAY)) u_step (.h_in(h_cur), .ok(cur_ok), .adv(tick),
                     .h_out(h_nxt), .wrap(wrap));
  hour_encode u_enc (.h24(h_nxt), .mode12(mode_12h), .bin(fmt_bin),
                     .hbyte(enc_byte));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mode_q  <= 1'b0;
      fmt_q   <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      mode_q <= mode_12h;
      fmt_q  <= fmt_bin;
      if (wr_valid) begin
        raw_q   <= wr_data;
        carry_q <= 1'b0;
      end else if (cur_ok) begin
        raw_q   <= enc_byte;
        carry_q <= wrap;
      end else begin
        carry_q <= 1'b0;
      end
    end
  end

  assign wr_ready  = 1'b1;
  assign rd_hour   = raw_q;
  assign day_carry = carry_q;

  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> rd_hour == $past(wr_data));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_valid && mode_12h == mode_q && fmt_bin == fmt_q) |=> $stable(rd_hour));
  p_carry_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> !day_carry);
  p_carry_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(day_carry) |-> ($past(tick) && !$past(wr_valid)));
  p_no_pm_24_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && cur_ok) |-> !rd_hour[PM_POS]);
  p_12h_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && cur_ok) |-> (!rd_hour[6] && rd_hour[5:0] != 6'd0));
endmodule

// File: tb/hour_counter_rtc_tb_top.sv
`timescale 1ns/1ps
module hour_counter_rtc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode_12h = 1'b0;
  logic       fmt_bin = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_hour;
  logic       day_carry;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hour_counter_rtc dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .mode_12h(mode_12h),
    .fmt_bin(fmt_bin), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_hour(rd_hour), .day_carry(day_carry));

  function automatic int enc(int h, int cfg);
    int v, d;
    bit m12, bin;
    m12 = cfg[1];
    bin = cfg[0];
    v = m12 ? h % 12 : h;
    if (m12 && v == 0) v = 12;
    d = bin ? v : (v / 10) * 16 + v % 10;
    if (m12 && h >= 12) d += 128;
    return d;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(int cfg);
    mode_12h = cfg[1];
    fmt_bin  = cfg[0];
  endtask

  task automatic do_write(int d);
    wr_valid = 1'b1;
    wr_data  = 8'(d);
    step();
    wr_valid = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    step();
    chk("R1 reset hour", rd_hour, 0);
    chk("R1 reset carry", day_carry, 0);
    chk("R8 ready", wr_ready, 1);
    rst_n = 1'b1;
    step();
    chk("R1 first cycle hour", rd_hour, 0);
    chk("R1 first cycle carry", day_carry, 0);

    // R5/R6 with R2/R3/R4: one full day of ticks in every encoding
    for (int cfg = 0; cfg < 4; cfg++) begin
      set_cfg(cfg);
      do_write(enc(0, cfg));
      chk("R8 write load", rd_hour, enc(0, cfg));
      for (int i = 1; i <= 24; i++) begin
        do_tick();
        chk(cfg[1] ? "R5 R3 tick 12h" : "R5 R2 tick 24h", rd_hour, enc(i % 24, cfg));
        chk("R6 carry", day_carry, (i == 24) ? 1 : 0);
      end
      step();
      chk("R6 carry drop", day_carry, 0);
      chk("R10 hold", rd_hour, enc(0, cfg));
    end

    // R3 literal spot values in 12-hour BCD
    set_cfg(2);
    do_write(8'h11);
    do_tick();
    chk("R3 noon 0x92", rd_hour, 8'h92);
    do_write(8'h91);
    do_tick();
    chk("R3 midnight 0x12", rd_hour, 8'h12);
    chk("R6 carry from 11PM", day_carry, 1);
    // R4 literal: 23 in 24h binary vs BCD
    set_cfg(1);
    do_write(8'h17);
    set_cfg(0);
    step();
    chk("R4 binary 0x17 to BCD 0x23", rd_hour, 8'h23);

    // R7: every hour across every ordered pair of encodings
    for (int from = 0; from < 4; from++)
      for (int to = 0; to < 4; to++)
        for (int h = 0; h < 24; h++) begin
          set_cfg(from);
          do_write(enc(h, from));
          set_cfg(to);
          step();
          chk("R7 convert", rd_hour, enc(h, to));
        end

    // R8: write wins over a tick in the same cycle
    set_cfg(0);
    do_write(8'h23);
    tick = 1'b1;
    do_write(8'h07);
    tick = 1'b0;
    chk("R8 write over tick", rd_hour, 8'h07);
    chk("R8 no carry on write", day_carry, 0);

    // R9: invalid bytes stay put
    do_write(8'h25);
    do_tick();
    chk("R9 invalid tick", rd_hour, 8'h25);
    chk("R9 invalid no carry", day_carry, 0);
    set_cfg(2);
    step();
    chk("R9 invalid mode change", rd_hour, 8'h25);
    set_cfg(3);
    do_write(8'h00);
    do_tick();
    chk("R9 12h zero", rd_hour, 8'h00);
    set_cfg(0);
    do_write(8'h1A);
    do_tick();
    chk("R9 bad BCD digit", rd_hour, 8'h1A);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule